// File: doc/BRIEF.md
# Dual-Edge Set/Clear Flag

This block keeps a single status flag that reacts to both edges of one clock. A set request sampled on a rising edge raises the flag right after that edge. A clear request sampled on the falling edge that follows lowers it right after that edge. When neither request applies at an edge, the flag keeps its value. The result is a pulse whose leading and trailing edges can fall half a clock period apart, without a faster clock.

Every storage element reacts to one clock polarity only, plus the asynchronous reset. The state is split into two halves. One half updates on rising edges and the other on falling edges. The flag is the exclusive-OR of the two halves. At each edge, the half that updates loads the wanted flag value XORed with the other half. Only one XOR input can change at a time, so the flag has no glitches. The set and clear requests come from logic clocked by the same clock. They must be stable around the edge that samples them.

Top module: `dedge_flag`

## Requirements
- R1: When `set_req` is 1 at a rising edge of `clk`, `flag` is 1 right after that edge.
- R2: When `clr_req` is 1 at a falling edge of `clk`, `flag` is 0 right after that edge.
- R3: When `set_req` is 0 at a rising edge, `flag` keeps its value across that edge, whatever `clr_req` is.
- R4: When `clr_req` is 0 at a falling edge, `flag` keeps its value across that edge, whatever `set_req` is.
- R5: While `rst` is 1, `flag` is 0. It drops to 0 as soon as `rst` rises, without waiting for a clock edge.
- R6: `flag` changes only directly after a clock edge. It stays constant for the rest of each half-period.
- R7: When both requests are 1 in one clock period, `flag` is 1 during the high phase and 0 after the falling edge, giving a half-period pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Asynchronous reset, active high |
| set_req | input | 1 | Raise request, sampled on rising edges |
| clr_req | input | 1 | Lower request, sampled on falling edges |
| flag | output | 1 | Flag value, the XOR of the two halves |

## Verification
Each result is due right after the edge that samples its request, with no cycle of latency: a set takes effect at its rising edge and a clear at its falling edge. The bench changes the requests 5 ns before the next rising edge. It compares the flag with its own model 3 ns after every edge, then again 8 ns after a rising edge to confirm that the value held. A reset is checked 1 ns after `rst` rises, before any clock edge has occurred.

// File: rtl/dedge_pkg.sv
package dedge_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // Wanted flag value after a rising edge: raise on request, else hold.
  function automatic logic want_after_rise(input logic req, input logic cur);
    return req ? 1'b1 : cur;
  endfunction

  // Wanted flag value after a falling edge: lower on request, else hold.
  function automatic logic want_after_fall(input logic req, input logic cur);
    return req ? 1'b0 : cur;
  endfunction

endpackage

// File: rtl/dedge_half.sv
module dedge_half
  import dedge_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic peer,
  output logic q
);

  logic cur;
  logic want;

  assign cur = q ^ peer;

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign want = want_after_rise(req, cur);

      always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= 1'b0;
        else     q <= want ^ peer;
      end

      // Without a request this half must not move across its edge.
      assert_rise_idle_holds_R3: assert property (
        @(posedge clk) disable iff (rst) !req |=> $stable(q)
      );
    end else begin : g_fall
      assign want = want_after_fall(req, cur);

      always_ff @(negedge clk or posedge rst) begin
        if (rst) q <= 1'b0;
        else     q <= want ^ peer;
      end

      assert_fall_idle_holds_R4: assert property (
        @(negedge clk) disable iff (rst) !req |=> $stable(q)
      );
    end
  endgenerate

endmodule

// File: rtl/dedge_merge.sv
module dedge_merge (
  input  logic rise_q,
  input  logic fall_q,
  output logic flag
);

  // Only one input moves per clock edge, so this XOR cannot glitch.
  assign flag = rise_q ^ fall_q;

endmodule

// File: rtl/dedge_flag.sv
module dedge_flag
  import dedge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);

  logic rise_q;
  logic fall_q;

  dedge_half #(.KIND(EDGE_RISE)) u_rise (
    .clk  (clk),
    .rst  (rst),
    .req  (set_req),
    .peer (fall_q),
    .q    (rise_q)
  );

  dedge_half #(.KIND(EDGE_FALL)) u_fall (
    .clk  (clk),
    .rst  (rst),
    .req  (clr_req),
    .peer (rise_q),
    .q    (fall_q)
  );

  dedge_merge u_merge (
    .rise_q (rise_q),
    .fall_q (fall_q),
    .flag   (flag)
  );

  // Checker state: samples taken at one edge, judged at the opposite edge.
  logic chk_set_q, chk_pre_rise_q, chk_rise_seen_q;
  logic chk_clr_q, chk_pre_fall_q, chk_fall_seen_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chk_set_q       <= 1'b0;
      chk_pre_rise_q  <= 1'b0;
      chk_rise_seen_q <= 1'b0;
    end else begin
      chk_set_q       <= set_req;
      chk_pre_rise_q  <= flag;
      chk_rise_seen_q <= 1'b1;
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      chk_clr_q       <= 1'b0;
      chk_pre_fall_q  <= 1'b0;
      chk_fall_seen_q <= 1'b0;
    end else begin
      chk_clr_q       <= clr_req;
      chk_pre_fall_q  <= flag;
      chk_fall_seen_q <= 1'b1;
    end
  end

  assert_set_raises_R1: assert property (
    @(negedge clk) disable iff (rst) chk_set_q |-> flag
  );

  assert_clr_lowers_R2: assert property (
    @(posedge clk) disable iff (rst) chk_clr_q |-> !flag
  );

  assert_rise_hold_R3: assert property (
    @(negedge clk) disable iff (rst)
      (chk_rise_seen_q && !chk_set_q) |-> (flag == chk_pre_rise_q)
  );

  assert_fall_hold_R4: assert property (
    @(posedge clk) disable iff (rst)
      (chk_fall_seen_q && !chk_clr_q) |-> (flag == chk_pre_fall_q)
  );

  assert_reset_low_R5: assert property (
    @(negedge clk) rst |-> !flag
  );

endmodule

// File: tb/tb_dedge_flag.sv
`timescale 1ns/1ps
module tb_dedge_flag;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_req = 1'b0;
  logic clr_req = 1'b0;
  logic flag;

  int checks = 0;
  int fails  = 0;
  logic model = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dedge_flag dut (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_req),
    .clr_req (clr_req),
    .flag    (flag)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: flag=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  // One clock period, started and ended 5 ns after a falling edge.
  task automatic cyc(input logic s, input logic c);
    set_req = s;
    clr_req = c;
    @(posedge clk);
    if (s) model = 1'b1;
    #3 check(flag, model, s ? "R1" : "R3");
    #5 check(flag, model, "R6");
    @(negedge clk);
    if (c) model = 1'b0;
    #3 check(flag, model, c ? (s ? "R7" : "R2") : "R4");
    #2;
  endtask

  task automatic t_reset_state();
    check(flag, 1'b0, "R5");
  endtask

  task automatic t_set_then_hold();
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
  endtask

  task automatic t_clear();
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1); // clear while already low
    cyc(1'b0, 1'b0);
  endtask

  task automatic t_pulse();
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
  endtask

  task automatic t_async_reset();
    cyc(1'b1, 1'b0);
    rst = 1'b1;
    #1 check(flag, 1'b0, "R5");
    @(posedge clk);
    #3 check(flag, 1'b0, "R5");
    @(negedge clk);
    #5 rst = 1'b0;
    model = 1'b0;
    check(flag, 1'b0, "R5");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      cyc(1'($urandom_range(1)), 1'($urandom_range(1)));
    end
  endtask

  initial begin
    @(negedge clk);
    #5;
    t_reset_state();
    rst = 1'b0;
    t_set_then_hold();
    t_clear();
    t_pulse();
    t_async_reset();
    t_random();
    report();
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    report();
    $finish;
  end

endmodule